// File: doc/BRIEF.md
# Bit-Serial Distributed Arithmetic Dot Product

This block forms the inner product of K input words with K coefficients that are fixed when the design is built, and it uses no multiplier. A load strobe captures all K words at once into per-word shift registers. On each following clock the registers give up their low bits. The bits at one position across all words form a K-bit address into a precomputed table. Each table entry holds the sum of the coefficients whose address bit is set. The table output is added into an accumulator at the binary weight of that bit position.

A parameter sets how many bit positions are consumed per clock, from one (bit-serial) up to the full word (fully parallel). With B bits per clock the table is replicated B times. A result then takes N/B clocks, whatever the value of K. Inputs may be treated as two's complement, in which case the weight of the top bit position is negative, or as unsigned. At the end of a computation the result is registered and a one-clock done pulse is raised.

Top module: `da_dot_product`

## Requirements
- R1: A load captures word k from din[k*N +: N], and the result delivered with done equals the sum over k of coef_k * x_k. With the default coefficients (13, -7, 100, -128 for k = 0..3), the default instance treats x_k as two's complement.
- R2: done is high for exactly one cycle, visible N/B clock edges after the edge that sampled load. That is 4 edges for B=2, 8 for B=1 and 1 for B=N=8.
- R3: The result width N + CW + clog2(K) + 1 holds the exact sum for extreme inputs such as all words at the most negative or largest value.
- R4: Table address bit j includes coefficient j. Address 0 yields zero and the all-ones address yields the sum of every coefficient. A single word equal to 1 returns that word's coefficient.
- R5: The bit-serial (B=1) and fully parallel (B=N) variants return the same sums as the default B=2 variant for the same inputs and signedness.
- R6: A load during a computation abandons it. No done is produced for the abandoned words, and the next done follows the new load after N/B edges with the new words' sum.
- R7: The result changes only on the cycle done is high. It holds across later loads until the next computation completes.
- R8: With signed data, the top bit position is weighted by -2^(N-1). With unsigned data it is weighted by +2^(N-1), so the word 0x80 alone gives -128*coef or +128*coef respectively.
- R9: After reset, result is 0 and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture din and start a new computation |
| din | input | K*N | K input words, word k in bits k*N +: N |
| result | output | N+CW+clog2(K)+1 | Signed inner product, held between completions |
| done | output | 1 | One-cycle pulse when result is updated |

## Verification
The edge that samples load counts as edge zero. The done pulse and the new result are due after edge N/B: edge 4 for the default instance, edge 8 for the serial one and edge 1 for the parallel one. All three instances share one stimulus. After each edge, the bench samples on the falling edge and compares done with its expected value in every cycle of the window. It checks the result only in the cycle where done is due. It also checks that results are still held at the window's end and across the next load. For the restart case, the second load restarts the count at zero, and the bench checks that no pulse appears for the abandoned words.

// File: rtl/da_pkg.sv
package da_pkg;

  // number of clocks one computation takes
  function automatic int unsigned digit_count(int unsigned n, int unsigned b);
    return n / b;
  endfunction

  // counter width for a step count, never below one bit
  function automatic int unsigned cnt_width(int unsigned steps);
    return (steps > 1) ? $clog2(steps) : 1;
  endfunction

  // true when bit position pos carries the negative weight
  function automatic bit is_sign_pos(int unsigned pos, int unsigned n, bit sgn);
    return sgn && (pos == n - 1);
  endfunction

endpackage

// File: rtl/da_subset_table.sv
module da_subset_table #(
  parameter int unsigned K = 4,
  parameter int unsigned CW = 8,
  parameter int unsigned TW = 11,
  parameter logic [K*CW-1:0] COEFS = '0
) (
  input  logic [K-1:0]          addr,
  output logic signed [TW-1:0]  sum
);
  localparam int unsigned ENTRIES = 2 ** K;

  // sum of the coefficients whose index bit is set in a
  function automatic logic signed [TW-1:0] subset_sum(int unsigned a);
    logic signed [TW-1:0] acc;
    logic signed [CW-1:0] c;
    logic signed [TW-1:0] ce;
    acc = '0;
    for (int j = 0; j < K; j++) begin
      if (a[j]) begin
        c   = COEFS[j*CW +: CW];
        ce  = c;
        acc = acc + ce;
      end
    end
    return acc;
  endfunction

  logic signed [TW-1:0] rom [ENTRIES];

  generate
    for (genvar a = 0; a < ENTRIES; a++) begin : g_rom
      assign rom[a] = subset_sum(a);
    end
  endgenerate

  assign sum = rom[addr];
endmodule

// File: rtl/da_shift_bank.sv
module da_shift_bank #(
  parameter int unsigned K = 4,
  parameter int unsigned N = 8,
  parameter int unsigned B = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift_en,
  input  logic [K*N-1:0] din,
  output logic [B*K-1:0] slices
);
  generate
    for (genvar k = 0; k < K; k++) begin : g_word
      logic [N-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr <= '0;
        else if (load)     sr <= din[k*N +: N];
        else if (shift_en) sr <= sr >> B;
      end
      // slice b of the table bus holds bit b of every word
      for (genvar b = 0; b < B; b++) begin : g_bit
        assign slices[b*K + k] = sr[b];
      end
    end
  endgenerate
endmodule

// File: rtl/da_weight_acc.sv
module da_weight_acc
  import da_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned B = 2,
  parameter int unsigned TW = 11,
  parameter int unsigned RW = 19,
  parameter bit SIGNED_DATA = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [B*TW-1:0]      tbl_bus,
  output logic                 busy,
  output logic signed [RW-1:0] result,
  output logic                 done
);
  localparam int unsigned STEPS = digit_count(N, B);
  localparam int unsigned CNTW  = cnt_width(STEPS);

  logic [CNTW-1:0]      cnt;
  logic signed [RW-1:0] acc;
  logic signed [RW-1:0] acc_next;
  logic signed [RW-1:0] digit_sum;
  logic signed [TW-1:0] t_sel;
  logic signed [RW-1:0] term;
  logic                 step_fire;
  logic                 last_step;

  assign step_fire = busy && !load;
  assign last_step = step_fire && (cnt == CNTW'(STEPS - 1));

  // weigh the B lookups of this digit, then place the digit
  always_comb begin
    digit_sum = '0;
    t_sel     = '0;
    term      = '0;
    for (int b = 0; b < B; b++) begin
      t_sel = tbl_bus[b*TW +: TW];
      term  = t_sel;
      term  = term <<< b;
      if (is_sign_pos(int'(cnt) * B + b, N, SIGNED_DATA))
        digit_sum = digit_sum - term;
      else
        digit_sum = digit_sum + term;
    end
    acc_next = acc + (digit_sum <<< (int'(cnt) * B));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        cnt  <= '0;
        acc  <= '0;
      end else if (step_fire) begin
        acc <= acc_next;
        cnt <= cnt + 1'b1;
        if (last_step) begin
          busy   <= 1'b0;
          result <= acc_next;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/da_dot_product.sv
module da_dot_product #(
  parameter int unsigned K = 4,
  parameter int unsigned N = 8,
  parameter int unsigned B = 2,
  parameter int unsigned CW = 8,
  parameter bit SIGNED_DATA = 1'b1,
  parameter logic [K*CW-1:0] COEFS = {8'h80, 8'h64, 8'hF9, 8'h0D},
  localparam int unsigned TW = CW + $clog2(K) + 1,
  localparam int unsigned RW = N + CW + $clog2(K) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [K*N-1:0]       din,
  output logic signed [RW-1:0] result,
  output logic                 done
);
  logic                 busy;
  logic [B*K-1:0]       slices;
  logic [B*TW-1:0]      tbl_bus;
  logic [K-1:0]         tbl_addr0;
  logic signed [TW-1:0] tbl_out0;

  da_shift_bank #(.K(K), .N(N), .B(B)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(load), .shift_en(busy),
    .din(din), .slices(slices)
  );

  generate
    for (genvar b = 0; b < B; b++) begin : g_tbl
      logic signed [TW-1:0] t_out;
      da_subset_table #(.K(K), .CW(CW), .TW(TW), .COEFS(COEFS)) u_tbl (
        .addr(slices[b*K +: K]), .sum(t_out)
      );
      assign tbl_bus[b*TW +: TW] = t_out;
    end
  endgenerate

  assign tbl_addr0 = slices[K-1:0];
  assign tbl_out0  = tbl_bus[TW-1:0];

  da_weight_acc #(
    .N(N), .B(B), .TW(TW), .RW(RW), .SIGNED_DATA(SIGNED_DATA)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .load(load), .tbl_bus(tbl_bus),
    .busy(busy), .result(result), .done(done)
  );
endmodule

// File: rtl/da_dot_product_chk.sv
module da_dot_product_chk #(
  parameter int unsigned K = 4,
  parameter int unsigned N = 8,
  parameter int unsigned B = 2,
  parameter int unsigned TW = 11,
  parameter int unsigned RW = 19
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 load,
  input logic                 done,
  input logic                 busy,
  input logic signed [RW-1:0] result,
  input logic [K-1:0]         tbl_addr0,
  input logic signed [TW-1:0] tbl_out0
);
  localparam int unsigned STEPS = N / B;

  // edges since the last sampled load, saturating past the window
  int unsigned since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since <= STEPS + 1;
    else if (load)            since <= 0;
    else if (since <= STEPS)  since <= since + 1;
  end

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done == (since == STEPS));

  assert_done_from_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  assert_load_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

  assert_empty_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_addr0 == '0) |-> (tbl_out0 == '0));
endmodule

bind da_dot_product da_dot_product_chk #(
  .K(K), .N(N), .B(B), .TW(TW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .done(done), .busy(busy),
  .result(result), .tbl_addr0(tbl_addr0), .tbl_out0(tbl_out0)
);

// File: tb/da_dot_product_tb.sv
module da_dot_product_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic load;
  logic [31:0] din;
  logic signed [18:0] res_a, res_s, res_p;
  logic done_a, done_s, done_p;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int prev_a = 0, prev_s = 0, prev_p = 0;

  localparam int COEF [4] = '{13, -7, 100, -128};

  always #10 clk = ~clk;

  da_dot_product u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .din(din), .result(res_a), .done(done_a)
  );
  da_dot_product #(.B(1), .SIGNED_DATA(1'b0)) u_dut_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .din(din), .result(res_s), .done(done_s)
  );
  da_dot_product #(.B(8)) u_dut_par (
    .clk(clk), .rst_n(rst_n), .load(load), .din(din), .result(res_p), .done(done_p)
  );

  function automatic int exp_dot(logic [31:0] v, bit sgn);
    int s = 0;
    for (int k = 0; k < 4; k++) begin
      int x;
      if (sgn) x = int'($signed(v[k*8 +: 8]));
      else     x = int'(v[k*8 +: 8]);
      s += COEF[k] * x;
    end
    return s;
  endfunction

  task automatic check(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic launch(logic [31:0] v);
    @(negedge clk);
    din  = v;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check("R7", "default result held over load", int'(res_a), prev_a);
    check("R7", "serial result held over load", int'(res_s), prev_s);
    check("R7", "parallel result held over load", int'(res_p), prev_p);
  endtask

  task automatic watch(logic [31:0] v, string tag);
    int ea, es;
    ea = exp_dot(v, 1'b1);
    es = exp_dot(v, 1'b0);
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      check("R2", "default done", int'(done_a), int'(c == 4));
      check("R2", "serial done", int'(done_s), int'(c == 8));
      check("R2", "parallel done", int'(done_p), int'(c == 1));
      if (c == 4) check(tag, "default result", int'(res_a), ea);
      if (c == 8) check({tag, "/R5"}, "serial result", int'(res_s), es);
      if (c == 1) check({tag, "/R5"}, "parallel result", int'(res_p), ea);
      if (c == 8) begin
        check("R7", "default result hold", int'(res_a), ea);
        check("R7", "parallel result hold", int'(res_p), ea);
      end
    end
    prev_a = ea;
    prev_s = es;
    prev_p = ea;
  endtask

  task automatic run(logic [31:0] v, string tag);
    launch(v);
    watch(v, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a_v, b_v;
    rst_n = 1'b0;
    load  = 1'b0;
    din   = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", "default result", int'(res_a), 0);
    check("R9", "serial result", int'(res_s), 0);
    check("R9", "parallel result", int'(res_p), 0);
    check("R9", "done low", int'(done_a | done_s | done_p), 0);

    // R4: single coefficient selection, empty and full subsets
    run(32'h0000_0001, "R4");
    run(32'h0000_0100, "R4");
    run(32'h0001_0000, "R4");
    run(32'h0100_0000, "R4");
    run(32'h0101_0101, "R4");
    run(32'h0000_0000, "R4");
    // R8: lone top-bit word, signed vs unsigned weight
    run(32'h0000_0080, "R8");
    run(32'h8000_0000, "R8");
    // R3: extremes
    run(32'h8080_8080, "R3");
    run(32'h7F7F_7F7F, "R3");
    run(32'hFFFF_FFFF, "R3");
    run(32'h807F_807F, "R3");
    run(32'h7F80_7F80, "R3");
    // R1: random vectors
    for (int i = 0; i < 30; i++) run($urandom, "R1");

    // R6: restart in the middle of a computation
    a_v = 32'h1234_5678;
    b_v = 32'h9ABC_DEF0;
    launch(a_v);
    @(negedge clk);
    @(negedge clk);
    check("R6", "default done before restart", int'(done_a), 0);
    check("R6", "serial done before restart", int'(done_s), 0);
    prev_p = exp_dot(a_v, 1'b1);
    run(b_v, "R6");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule